// File: doc/BRIEF.md
# Bus Fault Exception Frame Writer

This sequencer runs when a bus or address error is raised against the processor. In the cycle the fault is accepted it records everything the frame needs: the attributes of the failing access (function code, read/write flag, size, MMU origin), the fault address, PC, status register, vector number and current stack pointer. It then pushes the exception frame one 16-bit word at a time through a memory write port. The stack pointer moves down by two before every write, and the port holds each word until the memory acknowledges it.

Three frame layouts are supported. With `access_style` low, the frame is short when the fault address equals the address of the instruction in progress and long otherwise. With `access_style` high, the access-fault layout is used. A run-mode register records whether the block is idle, writing a frame, or holding a completed frame. A second fault that arrives while a frame is being written halts the processor for good, and the halt is signalled by a one-byte read strobe to a fixed address.

Top module: `fault_frame_writer`

## Requirements
- R1: After reset, `run_mode` is 0 (normal), `wr_req`, `done`, `halted` and `rd_strobe` are low, and `sp_out` is 0.
- R2: The access attributes, fault address, PC, SR, vector and stack pointer are sampled in the cycle `fault_req` is accepted. Later changes on those inputs do not alter any word of the frame.
- R3: Frame layout selection: `access_style`=1 gives the access-fault frame (30 words, format code 7), whatever the addresses. Otherwise `fault_addr`==`instr_addr` gives the short frame (16 words, code 0xA), and any other case gives the long frame (46 words, code 0xB).
- R4: In the short and long frames the status word is 0x0100 | fc[2:0] | rw<<6 | size<<4. It sits at word offset 5 from the final stack pointer, and the fault address occupies offsets 8 (upper half) and 9 (lower half).
- R5: In the access-fault frame the status word is fc[2:0] | rw<<8 | mmu<<10, at offset 6. The fault address appears twice: at offsets 4/5 and at offsets 10/11, upper half first.
- R6: Offset 0 (the last word pushed) holds SR. Offsets 1/2 hold the PC, upper half first. Offset 3 holds code<<12 | vector<<2. All other words are zero.
- R7: While a frame is being written, `wr_req` is high, `wr_addr` = `sp_out`−2, and the word stays on `wr_data` until `wr_ack`. Each acknowledged word lowers `sp_out` by 2, so a finished frame leaves `sp_out` = `sp_in` − 2×length.
- R8: `run_mode` encodes 0=normal, 1=writing, 2=frame done. The last acknowledged word moves it from 1 to 2 and raises `done` for exactly one cycle. `done_clr` in state 2 returns it to 0.
- R9: `fault_req` in state 1 sets `halted` and pulses `rd_strobe` once with `rd_addr`=0x00FFFF01. Once halted, no further writes are requested and `halted` stays high until reset.
- R10: `fault_req` in state 0 or 2 starts a new frame. While halted, `fault_req` and `done_clr` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_req | input | 1 | Bus/address error raised this cycle |
| access_style | input | 1 | Select the access-fault frame layout |
| fault_addr | input | 32 | Address of the failing access |
| instr_addr | input | 32 | Address of the instruction in progress |
| acc_fc | input | 3 | Function code of the failing access |
| acc_rw | input | 1 | 1 = read, 0 = write |
| acc_size | input | 2 | Size code of the failing access |
| mmu_fault | input | 1 | Fault came from address translation |
| vector | input | 8 | Exception vector number |
| pc | input | 32 | PC to stack |
| sr | input | 16 | Status register to stack |
| sp_in | input | 32 | Stack pointer at fault time |
| wr_ack | input | 1 | Memory accepted the current word |
| done_clr | input | 1 | Return from frame-done to normal |
| wr_req | output | 1 | Write request for one frame word |
| wr_addr | output | 32 | Write address |
| wr_data | output | 16 | Frame word |
| sp_out | output | 32 | Current stack pointer |
| rd_strobe | output | 1 | One-cycle halt byte read |
| rd_addr | output | 32 | Halt read address |
| run_mode | output | 2 | 0 normal, 1 writing, 2 frame done |
| done | output | 1 | One-cycle pulse when the frame is complete |
| halted | output | 1 | Double fault halt |

## Verification
A word counter that slips by one shows on the same cycle as a wrong `wr_data`, because the stacked SR, PC and status word no longer land at their offsets. It also changes the number of acknowledged writes, so `done` comes too early or too late. A stack pointer that is off shows at once on `wr_addr` and, by the end of the frame, on `sp_out`. A run mode that is misrouted, or a missed double fault, shows within one cycle as a wrong `run_mode`, as writes continuing after `halted`, or as a missing `rd_strobe`. The reference model compares every one of these outputs on every cycle, so each such fault is reported in the cycle it first appears.

// File: rtl/ffw_pkg.sv
package ffw_pkg;
  typedef enum logic [1:0] {RM_NORMAL = 2'd0, RM_WRITING = 2'd1, RM_DONE = 2'd2} run_mode_e;
  typedef enum logic [1:0] {FMT_SHORT = 2'd0, FMT_LONG = 2'd1, FMT_ACCESS = 2'd2} frame_fmt_e;

  typedef struct packed {
    logic [2:0] fc;
    logic       rw;
    logic [1:0] size;
    logic       mmu;
  } fault_attr_t;

  localparam int CNT_W = 6;

  function automatic logic [CNT_W-1:0] frame_len(frame_fmt_e f);
    case (f)
      FMT_SHORT:  return CNT_W'(16);
      FMT_LONG:   return CNT_W'(46);
      default:    return CNT_W'(30);
    endcase
  endfunction

  function automatic logic [15:0] status_word(frame_fmt_e f, fault_attr_t a);
    if (f == FMT_ACCESS) return {5'b0, a.mmu, 1'b0, a.rw, 5'b0, a.fc};
    return 16'h0100 | {9'b0, a.rw, a.size, 1'b0, a.fc};
  endfunction

  function automatic logic [15:0] fmtvec_word(frame_fmt_e f, logic [7:0] vec);
    logic [3:0] code;
    case (f)
      FMT_SHORT: code = 4'hA;
      FMT_LONG:  code = 4'hB;
      default:   code = 4'h7;
    endcase
    return {code, 2'b00, vec, 2'b00};
  endfunction

  // p counts from the final stack pointer upward (p = 0 is pushed last)
  function automatic logic [15:0] frame_word(frame_fmt_e f, logic [CNT_W-1:0] p, fault_attr_t a,
                                             logic [7:0] vec, logic [31:0] pcv,
                                             logic [31:0] fa, logic [15:0] srv);
    logic [15:0] w;
    w = '0;
    if (p == 0)      w = srv;
    else if (p == 1) w = pcv[31:16];
    else if (p == 2) w = pcv[15:0];
    else if (p == 3) w = fmtvec_word(f, vec);
    else if (f == FMT_ACCESS) begin
      if (p == 4 || p == 10)      w = fa[31:16];
      else if (p == 5 || p == 11) w = fa[15:0];
      else if (p == 6)            w = status_word(f, a);
    end else begin
      if (p == 5)      w = status_word(f, a);
      else if (p == 8) w = fa[31:16];
      else if (p == 9) w = fa[15:0];
    end
    return w;
  endfunction
endpackage

// File: rtl/ffw_capture.sv
module ffw_capture
  import ffw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        access_style,
  input  logic [31:0] fault_addr,
  input  logic [31:0] instr_addr,
  input  fault_attr_t attr_in,
  input  logic [7:0]  vector,
  input  logic [31:0] pc,
  input  logic [15:0] sr,
  output frame_fmt_e  fmt_now,
  output frame_fmt_e  fmt_q,
  output fault_attr_t attr_q,
  output logic [7:0]  vec_q,
  output logic [31:0] pc_q,
  output logic [31:0] fa_q,
  output logic [15:0] sr_q
);
  always_comb begin
    if (access_style)              fmt_now = FMT_ACCESS;
    else if (fault_addr == instr_addr) fmt_now = FMT_SHORT;
    else                           fmt_now = FMT_LONG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q  <= FMT_SHORT;
      attr_q <= '0;
      vec_q  <= '0;
      pc_q   <= '0;
      fa_q   <= '0;
      sr_q   <= '0;
    end else if (accept) begin
      fmt_q  <= fmt_now;
      attr_q <= attr_in;
      vec_q  <= vector;
      pc_q   <= pc;
      fa_q   <= fault_addr;
      sr_q   <= sr;
    end
  end
endmodule

// File: rtl/ffw_ctrl.sv
module ffw_ctrl
  import ffw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_req,
  input  logic [CNT_W-1:0] len_now,
  input  logic [31:0]      sp_in,
  input  logic             wr_ack,
  input  logic             done_clr,
  output logic             accept,
  output logic             halt_evt,
  output logic             push_ack,
  output run_mode_e        mode,
  output logic [CNT_W-1:0] cnt,
  output logic [31:0]      sp,
  output logic             halted,
  output logic             done,
  output logic             rd_strobe
);
  assign accept   = fault_req && !halted && (mode != RM_WRITING);
  assign halt_evt = fault_req && !halted && (mode == RM_WRITING);
  assign push_ack = !fault_req && !halted && (mode == RM_WRITING) && wr_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= RM_NORMAL;
      cnt       <= '0;
      sp        <= '0;
      halted    <= 1'b0;
      done      <= 1'b0;
      rd_strobe <= 1'b0;
    end else begin
      done      <= 1'b0;
      rd_strobe <= 1'b0;
      if (halt_evt) begin
        halted    <= 1'b1;
        rd_strobe <= 1'b1;
      end else if (accept) begin
        mode <= RM_WRITING;
        cnt  <= len_now - 1'b1;
        sp   <= sp_in;
      end else if (push_ack) begin
        sp <= sp - 32'd2;
        if (cnt == '0) begin
          mode <= RM_DONE;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (!halted && mode == RM_DONE && done_clr) begin
        mode <= RM_NORMAL;
      end
    end
  end
endmodule

// File: rtl/fault_frame_writer.sv
module fault_frame_writer
  import ffw_pkg::*;
#(
  parameter logic [31:0] HALT_ADDR = 32'h00FF_FF01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fault_req,
  input  logic        access_style,
  input  logic [31:0] fault_addr,
  input  logic [31:0] instr_addr,
  input  logic [2:0]  acc_fc,
  input  logic        acc_rw,
  input  logic [1:0]  acc_size,
  input  logic        mmu_fault,
  input  logic [7:0]  vector,
  input  logic [31:0] pc,
  input  logic [15:0] sr,
  input  logic [31:0] sp_in,
  input  logic        wr_ack,
  input  logic        done_clr,
  output logic        wr_req,
  output logic [31:0] wr_addr,
  output logic [15:0] wr_data,
  output logic [31:0] sp_out,
  output logic        rd_strobe,
  output logic [31:0] rd_addr,
  output logic [1:0]  run_mode,
  output logic        done,
  output logic        halted
);
  fault_attr_t      attr_in, attr_q;
  frame_fmt_e       fmt_now, fmt_q;
  logic [7:0]       vec_q;
  logic [31:0]      pc_q, fa_q, sp_q;
  logic [15:0]      sr_q;
  logic             accept, halt_evt, push_ack;
  run_mode_e        mode;
  logic [CNT_W-1:0] cnt;

  assign attr_in = '{fc: acc_fc, rw: acc_rw, size: acc_size, mmu: mmu_fault};

  ffw_capture u_capture (
    .clk(clk), .rst_n(rst_n), .accept(accept), .access_style(access_style),
    .fault_addr(fault_addr), .instr_addr(instr_addr), .attr_in(attr_in),
    .vector(vector), .pc(pc), .sr(sr), .fmt_now(fmt_now), .fmt_q(fmt_q),
    .attr_q(attr_q), .vec_q(vec_q), .pc_q(pc_q), .fa_q(fa_q), .sr_q(sr_q)
  );

  ffw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .len_now(frame_len(fmt_now)),
    .sp_in(sp_in), .wr_ack(wr_ack), .done_clr(done_clr), .accept(accept),
    .halt_evt(halt_evt), .push_ack(push_ack), .mode(mode), .cnt(cnt), .sp(sp_q),
    .halted(halted), .done(done), .rd_strobe(rd_strobe)
  );

  assign wr_req   = (mode == RM_WRITING) && !halted;
  assign wr_addr  = sp_q - 32'd2;
  assign wr_data  = frame_word(fmt_q, cnt, attr_q, vec_q, pc_q, fa_q, sr_q);
  assign sp_out   = sp_q;
  assign rd_addr  = HALT_ADDR;
  assign run_mode = mode;
endmodule

// File: rtl/ffw_checker.sv
module ffw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        fault_req,
  input logic        done_clr,
  input logic        wr_req,
  input logic        wr_ack,
  input logic [31:0] sp_out,
  input logic        rd_strobe,
  input logic [31:0] rd_addr,
  input logic [1:0]  run_mode,
  input logic        done,
  input logic        halted
);
  AST_WR_ONLY_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (run_mode == 2'd1) && !halted); // R9
  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_ack && !fault_req) |=> sp_out == $past(sp_out) - 32'd2); // R7
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R9
  AST_HALT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> halted && (rd_addr == 32'h00FF_FF01)); // R9
  AST_DONE_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_mode == 2'd2); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_CLEAR_TO_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode == 2'd2 && done_clr && !fault_req && !halted) |=> run_mode == 2'd0); // R8
endmodule

bind fault_frame_writer ffw_checker u_ffw_checker (
  .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .done_clr(done_clr),
  .wr_req(wr_req), .wr_ack(wr_ack), .sp_out(sp_out), .rd_strobe(rd_strobe),
  .rd_addr(rd_addr), .run_mode(run_mode), .done(done), .halted(halted)
);

// File: tb/test_fault_frame_writer.sv
`timescale 1ns/1ps
module test_fault_frame_writer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, fault_req = 1'b0, access_style = 1'b0;
  logic [31:0] fault_addr = '0, instr_addr = '0, pc = '0, sp_in = '0;
  logic [2:0]  acc_fc = '0;
  logic        acc_rw = 1'b0, mmu_fault = 1'b0, wr_ack = 1'b0, done_clr = 1'b0;
  logic [1:0]  acc_size = '0;
  logic [7:0]  vector = '0;
  logic [15:0] sr = '0;
  logic        wr_req, rd_strobe, done, halted;
  logic [31:0] wr_addr, sp_out, rd_addr;
  logic [15:0] wr_data;
  logic [1:0]  run_mode;

  fault_frame_writer i_fault_frame_writer (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, ack_mode = 0, dut_words = 0;
  bit finished = 0;

  // behavioural reference model
  int          m_mode = 0;
  bit          m_halt = 0, m_done = 0, m_rd = 0;
  logic [31:0] m_sp = '0;
  logic [15:0] m_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void build_frame();
    logic [15:0] w[46];
    int n, code;
    for (int i = 0; i < 46; i++) w[i] = 16'h0;
    if (access_style) begin n = 30; code = 7; end
    else if (fault_addr == instr_addr) begin n = 16; code = 10; end
    else begin n = 46; code = 11; end
    w[0] = sr;
    w[1] = pc[31:16];
    w[2] = pc[15:0];
    w[3] = 16'(code * 4096 + vector * 4);
    if (code == 7) begin
      w[4] = fault_addr[31:16]; w[5] = fault_addr[15:0];
      w[10] = fault_addr[31:16]; w[11] = fault_addr[15:0];
      w[6] = 16'(acc_fc + (acc_rw ? 256 : 0) + (mmu_fault ? 1024 : 0));
    end else begin
      w[8] = fault_addr[31:16]; w[9] = fault_addr[15:0];
      w[5] = 16'(256 + acc_fc + (acc_rw ? 64 : 0) + acc_size * 16);
    end
    m_q.delete();
    for (int i = n - 1; i >= 0; i--) m_q.push_back(w[i]);
  endfunction

  always @(posedge clk) begin
    m_done = 0;
    m_rd = 0;
    if (rst_n && !m_halt) begin
      if (fault_req && m_mode == 1) begin
        m_halt = 1; m_rd = 1;
      end else if (fault_req) begin
        m_mode = 1; m_sp = sp_in; build_frame();
      end else if (m_mode == 1 && wr_ack) begin
        m_sp = m_sp - 32'd2;
        void'(m_q.pop_front());
        if (m_q.size() == 0) begin m_mode = 2; m_done = 1; end
      end else if (m_mode == 2 && done_clr) begin
        m_mode = 0;
      end
    end
  end

  // compare every cycle away from the active edge, then drive the acknowledge
  always @(negedge clk) begin
    if (rst_n) begin
      check(wr_req === (m_mode == 1 && !m_halt), "R7/R9 wr_req", 32'(wr_req), 32'(m_mode == 1 && !m_halt));
      if (m_mode == 1 && !m_halt) begin
        check(wr_addr === m_sp - 32'd2, "R7 wr_addr", wr_addr, m_sp - 32'd2);
        check(wr_data === m_q[0], "R2/R4/R5/R6 wr_data", 32'(wr_data), 32'(m_q[0]));
      end
      check(sp_out === m_sp, "R7 sp_out", sp_out, m_sp);
      check(run_mode === 2'(m_mode), "R8/R10 run_mode", 32'(run_mode), 32'(m_mode));
      check(done === m_done, "R8 done", 32'(done), 32'(m_done));
      check(halted === m_halt, "R9 halted", 32'(halted), 32'(m_halt));
      check(rd_strobe === m_rd, "R9 rd_strobe", 32'(rd_strobe), 32'(m_rd));
      if (m_rd) check(rd_addr === 32'h00FF_FF01, "R9 rd_addr", rd_addr, 32'h00FF_FF01);
    end
    cyc++;
    wr_ack = (ack_mode == 0) ? 1'b1 : (cyc % 3 == 0);
    if (wr_req && wr_ack) dut_words++;
  end

  task automatic fault(input bit style, input logic [31:0] fa, input logic [31:0] ia,
                       input logic [2:0] fc, input bit rw, input logic [1:0] sz, input bit mmu,
                       input logic [7:0] vec, input logic [31:0] pcv, input logic [15:0] srv,
                       input logic [31:0] sp);
    access_style = style; fault_addr = fa; instr_addr = ia; acc_fc = fc; acc_rw = rw;
    acc_size = sz; mmu_fault = mmu; vector = vec; pc = pcv; sr = srv; sp_in = sp;
    fault_req = 1'b1;
    @(negedge clk);
    fault_req = 1'b0;
    // R2: disturb every live input right after acceptance
    acc_fc = ~acc_fc; acc_rw = ~acc_rw; acc_size = ~acc_size; mmu_fault = ~mmu_fault;
    fault_addr = ~fault_addr; pc = ~pc; sr = ~sr; vector = ~vector; sp_in = 32'h0;
    access_style = ~access_style;
  endtask

  task automatic frame_end(input int len, input logic [31:0] sp0, input int w0);
    while (m_mode != 2) @(negedge clk);
    @(negedge clk);
    check(dut_words - w0 == len, "R3 frame length", 32'(dut_words - w0), 32'(len));
    check(sp_out === sp0 - 32'(2 * len), "R7 final sp", sp_out, sp0 - 32'(2 * len));
  endtask

  task automatic clear();
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int w0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(run_mode === 2'd0, "R1 run_mode", 32'(run_mode), 0);
    check(!wr_req && !done && !halted && !rd_strobe, "R1 outputs", 32'({wr_req, done, halted, rd_strobe}), 0);
    check(sp_out === 32'h0, "R1 sp_out", sp_out, 0);

    // short frame, ack every cycle
    w0 = dut_words;
    fault(1'b0, 32'h0000_4A10, 32'h0000_4A10, 3'd6, 1'b1, 2'd2, 1'b0, 8'd2, 32'h0000_4A14, 16'h2704, 32'h0001_0000);
    frame_end(16, 32'h0001_0000, w0);
    clear();

    // long frame with stalled acknowledges
    ack_mode = 1;
    w0 = dut_words;
    fault(1'b0, 32'h00AB_CDE0, 32'h0000_1000, 3'd1, 1'b0, 2'd3, 1'b1, 8'd3, 32'h0000_1002, 16'h0010, 32'h0002_0000);
    frame_end(46, 32'h0002_0000, w0);

    // R10: new fault taken from frame-done state, access-fault layout with MMU origin
    w0 = dut_words;
    fault(1'b1, 32'hDEAD_BEE0, 32'h0000_3000, 3'd5, 1'b1, 2'd1, 1'b1, 8'd2, 32'hCAFE_0008, 16'h2000, 32'h0003_0000);
    frame_end(30, 32'h0003_0000, w0);
    clear();

    // R3: access-fault layout even when addresses match
    ack_mode = 0;
    w0 = dut_words;
    fault(1'b1, 32'h0000_5000, 32'h0000_5000, 3'd2, 1'b0, 2'd0, 1'b0, 8'd56, 32'h0000_5004, 16'h0700, 32'h0004_0000);
    frame_end(30, 32'h0004_0000, w0);
    clear();

    // R9: second fault while writing halts
    ack_mode = 1;
    fault(1'b0, 32'h0000_7000, 32'h0000_6000, 3'd5, 1'b1, 2'd2, 1'b0, 8'd2, 32'h0000_6002, 16'h2300, 32'h0005_0000);
    repeat (6) @(negedge clk);
    fault_req = 1'b1;
    @(negedge clk);
    fault_req = 1'b0;
    repeat (3) @(negedge clk);
    // R10: faults and clears are ignored while halted
    fault_req = 1'b1; done_clr = 1'b1;
    @(negedge clk);
    fault_req = 1'b0; done_clr = 1'b0;
    repeat (6) @(negedge clk);
    check(halted === 1'b1 && wr_req === 1'b0, "R9 halt holds", 32'({halted, wr_req}), 32'h2);
    check(run_mode === 2'd1, "R10 mode frozen", 32'(run_mode), 1);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule